// File: doc/BRIEF.md
# Selectable-Rate Tick Source with Debounced Manual Step

This block produces the count enable for a synchronous counter. The enable is a single-cycle pulse on `tick_o`, and it comes from one of two sources. The first is a slow timer. A prescaler turns the system clock into a base tick of nominally 200 ms. A synchronous 4-bit divider counts those base ticks, and a 4-way selector picks one of its taps, so the output period is 2, 4, 8 or 16 base periods (400 ms to 3.2 s). The second source is a changeover push button. Its two contacts feed a set-reset latch that ignores contact bounce, and the rising edge of the latch becomes one output pulse.

The divider has a clear made of two inputs that acts only when both are high. The selector has an inhibit input that silences the timer path while the divider keeps counting. A new rate code is adopted only on a period boundary of the rate in use, so a change never shortens or splits a period.

Top module: `rate_tick_source`

## Requirements
- R1: After reset, `tick_o` is low, the divider count is zero, the button latch reads released, and the rate in use is divide-by-2 whatever `rate_sel` holds.
- R2: The base tick occurs once every `BASE_CYCLES` clock cycles, and the divider advances by one on each base tick.
- R3: With `src_sel`=0, rate code 0, 1, 2 or 3 gives ticks spaced 2, 4, 8 or 16 times `BASE_CYCLES` clock cycles.
- R4: A new `rate_sel` value takes effect at the next tick of the rate in use, or at a divider clear, and never causes an extra tick.
- R5: While `sel_inhibit` is high, the timer path produces no ticks. The divider keeps counting, so ticks resume on the original phase.
- R6: The divider clears only when `clr_a` and `clr_b` are both high. The clear zeroes the count, suppresses every tap, overrides counting and adopts `rate_sel`. Either input alone has no effect.
- R7: The latch sets (pressed) when `make_n` is low and clears (released) when `break_n` is low with `make_n` high. With both high it holds. Contact bounce gives exactly one tick per press and none on release.
- R8: In button mode, `tick_o` is high for the cycle that follows the 4th rising clock edge after `make_n` falls (two synchroniser stages, the latch and the output register).
- R9: `src_sel`=1 selects the button and `src_sel`=0 the timer. The source that is not selected produces no tick.
- R10: Each tick lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| make_n | input | 1 | Button contact that closes on press, low when closed |
| break_n | input | 1 | Button contact that opens on press, low when closed |
| src_sel | input | 1 | 0 selects the timer, 1 selects the button |
| rate_sel | input | RATE_W | Divider tap code: 0 gives /2, 3 gives /16 |
| sel_inhibit | input | 1 | High forces the timer path output low |
| clr_a | input | 1 | Divider clear, first leg |
| clr_b | input | 1 | Divider clear, second leg |
| tick_o | output | 1 | One-cycle count enable |

## Verification
Timer ticks are checked as the spacing between consecutive pulses rather than as absolute times. That spacing must be an exact multiple of `BASE_CYCLES`: 2, 4, 8 or 16 times, or a known partial count across a rate change or an inhibit window. The scoreboard therefore queues expected gaps and compares them as each pulse appears. A button pulse is due one cycle after the 4th rising edge that follows the contact closing, and the bench samples the output at each falling edge on either side of that cycle. Checks for "no effect" count pulses over whole-period windows that start half a cycle after a falling edge, so a window never splits a period.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic {
    SRC_TIMER  = 1'b0,
    SRC_BUTTON = 1'b1
  } src_e;
endpackage

// File: rtl/rts_prescaler.sv
// Base tick generator: one pulse every BASE_CYCLES clocks (R2).
module rts_prescaler #(
  parameter int unsigned BASE_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic base_tick
);
  localparam int unsigned CW = (BASE_CYCLES > 1) ? $clog2(BASE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BASE_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign base_tick = (cnt == LAST);
endmodule

// File: rtl/rts_divider.sv
// Synchronous binary divider on the base tick; tap k fires when the low k+1
// bits wrap, i.e. every 2^(k+1) base ticks (R3). Clear needs both legs (R6).
module rts_divider #(
  parameter int unsigned TAPS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            base_tick,
  input  logic            clr,
  output logic [TAPS-1:0] tap
);
  logic [TAPS-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr)       cnt <= '0;
    else if (base_tick) cnt <= cnt + 1'b1;
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign tap[k] = base_tick & ~clr & (&cnt[k:0]);
  end
endmodule

// File: rtl/rts_rate_mux.sv
// Tap selector with boundary-synchronous rate adoption (R4) and inhibit (R5).
module rts_rate_mux #(
  parameter int unsigned RATE_W = 2,
  parameter int unsigned TAPS   = 1 << RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAPS-1:0]   tap,
  input  logic              clr,
  input  logic [RATE_W-1:0] rate_req,
  input  logic              inhibit,
  output logic              sel_tick
);
  logic [RATE_W-1:0] rate_q;
  logic              boundary;

  assign boundary = tap[rate_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rate_q <= '0;
    else if (clr || boundary)  rate_q <= rate_req;
  end

  assign sel_tick = boundary & ~inhibit;
endmodule

// File: rtl/rts_button.sv
// Changeover-contact debouncer: synchronisers, set-reset latch, rising-edge
// pulse (R7, R8).
module rts_button #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic make_n,
  input  logic break_n,
  output logic press_tick
);
  logic [SYNC_STAGES-1:0] mk_q;
  logic [SYNC_STAGES-1:0] bk_q;
  logic                   held;
  logic                   held_prev;
  logic                   held_nxt;

  if (SYNC_STAGES == 1) begin : g_sync1
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mk_q <= '1;
        bk_q <= '0;
      end else begin
        mk_q <= make_n;
        bk_q <= break_n;
      end
    end
  end else begin : g_syncn
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mk_q <= '1;
        bk_q <= '0;
      end else begin
        mk_q <= {mk_q[SYNC_STAGES-2:0], make_n};
        bk_q <= {bk_q[SYNC_STAGES-2:0], break_n};
      end
    end
  end

  always_comb begin
    unique case ({mk_q[SYNC_STAGES-1], bk_q[SYNC_STAGES-1]})
      2'b01:   held_nxt = 1'b1;
      2'b00:   held_nxt = 1'b1;
      2'b10:   held_nxt = 1'b0;
      default: held_nxt = held;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_prev <= 1'b0;
    end else begin
      held      <= held_nxt;
      held_prev <= held;
    end
  end

  assign press_tick = held & ~held_prev;
endmodule

// File: rtl/rate_tick_source.sv
module rate_tick_source
  import rts_pkg::*;
#(
  parameter int unsigned BASE_CYCLES = 10_000_000,
  parameter int unsigned RATE_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              make_n,
  input  logic              break_n,
  input  logic              src_sel,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              sel_inhibit,
  input  logic              clr_a,
  input  logic              clr_b,
  output logic              tick_o
);
  localparam int unsigned TAPS = 1 << RATE_W;

  logic            base_tick;
  logic            div_clr;
  logic [TAPS-1:0] tap;
  logic            timer_tick;
  logic            press_tick;
  src_e            src;

  assign div_clr = clr_a & clr_b;   // R6: both legs required
  assign src     = src_e'(src_sel);

  rts_prescaler #(.BASE_CYCLES(BASE_CYCLES)) u_pre (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick)
  );

  rts_divider #(.TAPS(TAPS)) u_div (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .clr(div_clr), .tap(tap)
  );

  rts_rate_mux #(.RATE_W(RATE_W), .TAPS(TAPS)) u_mux (
    .clk(clk), .rst_n(rst_n), .tap(tap), .clr(div_clr),
    .rate_req(rate_sel), .inhibit(sel_inhibit), .sel_tick(timer_tick)
  );

  rts_button #(.SYNC_STAGES(SYNC_STAGES)) u_btn (
    .clk(clk), .rst_n(rst_n), .make_n(make_n), .break_n(break_n),
    .press_tick(press_tick)
  );

  // R9: source choice, registered output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  tick_o <= 1'b0;
    else if (src == SRC_BUTTON)  tick_o <= press_tick;
    else                         tick_o <= timer_tick;
  end
endmodule

// File: rtl/rate_tick_source_chk.sv
module rate_tick_source_chk #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic make_n,
  input logic src_sel,
  input logic sel_inhibit,
  input logic clr_a,
  input logic clr_b,
  input logic tick_o
);
  localparam int unsigned LAT = SYNC_STAGES + 2;

  logic [LAT-1:0] mk_hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mk_hist <= '1;
    else        mk_hist <= {mk_hist[LAT-2:0], make_n};
  end

  a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && $stable(src_sel)) |=> !tick_o);

  a_r6_clear_silences: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_a && clr_b && !src_sel) |=> !tick_o);

  a_r5_inhibit_silences: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_inhibit && !src_sel) |=> !tick_o);

  a_r8_button_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && $past(src_sel)) |-> !mk_hist[LAT-1]);
endmodule

bind rate_tick_source rate_tick_source_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/rate_tick_source_bench.sv
module rate_tick_source_bench;
  localparam int CLK_PERIOD = 10;
  localparam int B          = 5;

  logic       clk = 1'b0;
  logic       rst_n, make_n, break_n, src_sel, sel_inhibit, clr_a, clr_b;
  logic [1:0] rate_sel;
  logic       tick_o;

  int    n_vec = 0, n_bad = 0;
  int    cyc = 0, tick_cnt = 0, last_cyc = 0;
  bit    armed = 0, have_ref = 0, done = 0;
  int    gap_q[$];
  string tag_q[$];
  int    g_exp;
  string g_tag;
  int    cnt;
  bit    smp [1:6];

  always #(CLK_PERIOD/2) clk = ~clk;

  rate_tick_source #(.BASE_CYCLES(B), .RATE_W(2), .SYNC_STAGES(2)) u_rate_tick_source (
    .clk(clk), .rst_n(rst_n), .make_n(make_n), .break_n(break_n),
    .src_sel(src_sel), .rate_sel(rate_sel), .sel_inhibit(sel_inhibit),
    .clr_a(clr_a), .clr_b(clr_b), .tick_o(tick_o)
  );

  // Monitor: pops expected gaps and compares
  always @(negedge clk) begin
    cyc++;
    if (tick_o) begin
      tick_cnt++;
      if (armed) begin
        if (have_ref) begin
          n_vec++;
          if (gap_q.size() == 0) begin
            n_bad++;
            $display("FAIL R4: unexpected tick, gap %0d expected none", cyc - last_cyc);
          end else begin
            g_exp = gap_q.pop_front();
            g_tag = tag_q.pop_front();
            if (cyc - last_cyc != g_exp) begin
              n_bad++;
              $display("FAIL %s: tick gap %0d expected %0d", g_tag, cyc - last_cyc, g_exp);
            end
          end
        end
        last_cyc = cyc;
        have_ref = 1;
      end
    end
  end

  task automatic push_gap(int g, string tag);
    gap_q.push_back(g);
    tag_q.push_back(tag);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sync_arm();
    have_ref = 0;
    armed    = 1;
    wait (have_ref);
  endtask

  task automatic drain();
    wait (gap_q.size() == 0);
    armed = 0;
  endtask

  task automatic wait_tick();
    int s;
    s = tick_cnt;
    wait (tick_cnt != s);
  endtask

  task automatic window(int n, output int c);
    int s;
    #1;
    s = tick_cnt;
    repeat (n) @(negedge clk);
    #1;
    c = tick_cnt - s;
  endtask

  task automatic clear_pulse();
    @(negedge clk);
    clr_a = 1; clr_b = 1;
    @(negedge clk);
    clr_a = 0; clr_b = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual 1 expected 0");
    finish_run();
  end

  initial begin
    rst_n = 0; make_n = 1; break_n = 0; src_sel = 0; rate_sel = 2'd3;
    sel_inhibit = 0; clr_a = 0; clr_b = 0;
    repeat (3) @(negedge clk);
    chk(tick_o == 1'b0, "R1", "tick during reset", tick_o, 0);
    rst_n = 1;

    // R1: rate /2 in use after reset, code 3 adopted at first boundary
    sync_arm();
    push_gap(14*B, "R1");
    push_gap(16*B, "R1");
    drain();

    // R3 R2: each rate code after a clear
    for (int k = 0; k < 4; k++) begin
      rate_sel = 2'(k);
      clear_pulse();
      sync_arm();
      for (int j = 0; j < 3; j++) push_gap((2 << k) * B, "R3 R2");
      drain();
    end

    // R4: upward then downward rate change
    rate_sel = 2'd0;
    clear_pulse();
    sync_arm();
    rate_sel = 2'd3;
    push_gap(2*B, "R4"); push_gap(12*B, "R4"); push_gap(16*B, "R4");
    wait (gap_q.size() == 0);
    rate_sel = 2'd0;
    push_gap(16*B, "R4"); push_gap(2*B, "R4"); push_gap(2*B, "R4");
    drain();

    // R5: inhibit over three periods, phase kept
    sync_arm();
    sel_inhibit = 1;
    repeat (7*B) @(negedge clk);
    sel_inhibit = 0;
    push_gap(8*B, "R5");
    drain();

    // R6: both legs silence, single leg has no effect
    @(negedge clk);
    clr_a = 1; clr_b = 1;
    window(10*B, cnt);
    chk(cnt == 0, "R6", "ticks with both clear legs high", cnt, 0);
    clr_b = 0;
    wait_tick();
    window(4*B, cnt);
    chk(cnt == 2, "R6", "ticks with clr_a alone", cnt, 2);
    clr_a = 0; clr_b = 1;
    window(4*B, cnt);
    chk(cnt == 2, "R6", "ticks with clr_b alone", cnt, 2);
    clr_b = 0;

    // R9: timer ignored in button mode
    @(negedge clk);
    src_sel = 1;
    window(10*B, cnt);
    chk(cnt == 0, "R9", "timer ticks in button mode", cnt, 0);

    // R9: button ignored in timer mode (timer held in clear)
    src_sel = 0; clr_a = 1; clr_b = 1;
    break_n = 1;
    repeat (3) @(negedge clk);
    make_n = 0;
    window(12, cnt);
    chk(cnt == 0, "R9", "button ticks in timer mode", cnt, 0);
    make_n = 1; break_n = 0;
    repeat (6) @(negedge clk);
    clr_a = 0; clr_b = 0; src_sel = 1;
    repeat (4) @(negedge clk);

    // R8 R7: bouncing press, latency 4 edges
    break_n = 1;
    repeat (3) @(negedge clk);
    make_n = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      smp[i] = tick_o;
      if (i <= 4) make_n = (i % 2 == 1) ? 1'b1 : 1'b0;
    end
    chk(smp[1] == 0, "R8", "tick after edge 1", smp[1], 0);
    chk(smp[2] == 0, "R8", "tick after edge 2", smp[2], 0);
    chk(smp[3] == 0, "R8", "tick after edge 3", smp[3], 0);
    chk(smp[4] == 1, "R8", "tick after edge 4", smp[4], 1);
    chk(smp[5] == 0, "R10", "tick after edge 5", smp[5], 0);
    window(20, cnt);
    chk(cnt == 0, "R7", "extra ticks during bounce", cnt, 0);

    // R7: bouncing release gives no tick
    make_n = 1;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      break_n = (i % 2 == 0) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    break_n = 0;
    window(12, cnt);
    chk(cnt == 0, "R7", "ticks on release", cnt, 0);

    // R7: clean second press gives one tick
    break_n = 1;
    repeat (2) @(negedge clk);
    make_n = 0;
    window(10, cnt);
    chk(cnt == 1, "R7", "ticks on second press", cnt, 1);
    make_n = 1; break_n = 0;
    repeat (5) @(negedge clk);

    finish_run();
  end
endmodule